// File: doc/BRIEF.md
# Tape Record Framing Parser

This block turns a raw byte stream holding a sequence of variable-length tape records into delivered payload bytes and a set of one-cycle event pulses. Every record is framed by a 32-bit length field, least significant byte first, both before and after its payload. When the length is odd, one filler byte sits between the payload and the trailing copy. A length of zero is a file mark: it stands alone, with no trailing copy. When the source has nothing further to send at a record boundary, it signals end of stream, and the block reports end of medium.

Bytes arrive on a valid/ready input with a separate end-of-stream strobe. Payload bytes pass straight through to a valid/ready output that carries first and last flags. Header and trailer bytes are absorbed. Filler bytes are also absorbed. The record length, and every event (record start, record done, file mark, end of medium, and the three error kinds), are registered. They appear in the cycle after the byte or strobe that caused them. A record whose trailing copy disagrees with its header is flagged, and the parser carries on with the next header. An oversize header cannot be resynchronised, so the parser drops bytes until end of stream.

Top module: `tape_frame_parser`

## Requirements
- R1: A length field is four bytes, least significant first. One cycle after the fourth header byte is accepted with a value from 1 to MAX_LEN, rec_start_o pulses and rec_len_o holds that value until the next record start. rec_len_o is 0 after reset.
- R2: During the payload, in_ready_o equals out_ready_i, and out_valid_o/out_data_o mirror in_valid_i/in_data_i. out_first_o marks the first payload byte and out_last_o the byte at which the header count is used up. Outside the payload, out_valid_o is 0 and in_ready_o is 1.
- R3: For an odd length, exactly one byte after the payload is accepted and never delivered. The next four bytes are then the trailer. An odd record of N bytes therefore delivers exactly N bytes.
- R4: When the trailer equals the header, rec_done_o pulses one cycle after the last trailer byte is accepted.
- R5: When the trailer differs from the header, frame_err_o pulses instead of rec_done_o, and the next byte starts a new header.
- R6: A header of value 0 pulses file_mark_o. It consumes no trailer, and the next byte starts a new header.
- R7: A header above MAX_LEN (default 65536) pulses len_err_o. All later bytes are accepted and discarded, with no events, until in_eos_i. After in_eos_i, parsing restarts at a header.
- R8: in_eos_i with no partial header pending, outside payload, filler and trailer, pulses eom_o one cycle later.
- R9: in_eos_i inside a header, payload, filler or trailer pulses trunc_err_o one cycle later, and the next byte starts a header.
- R10: When a byte is accepted in the same cycle as in_eos_i, the byte is processed first. A file mark or a completed record on that byte is reported in the same cycle as eom_o.
- R11: After reset, in_ready_o is 1, out_valid_o is 0 and all event outputs are 0.
- R12: A record of exactly MAX_LEN bytes is accepted and fully delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_data_i | input | 8 | Input byte |
| in_eos_i | input | 1 | End-of-stream strobe, applied after any byte accepted in that cycle |
| in_ready_o | output | 1 | Input byte accepted when high with in_valid_i |
| out_valid_o | output | 1 | Payload byte valid |
| out_data_o | output | 8 | Payload byte |
| out_first_o | output | 1 | First payload byte of the record |
| out_last_o | output | 1 | Last payload byte of the record |
| out_ready_i | input | 1 | Downstream accepts payload byte |
| rec_len_o | output | LEN_W (17) | Length from the last valid header |
| rec_start_o | output | 1 | Pulse: valid header parsed |
| rec_done_o | output | 1 | Pulse: trailer matched |
| file_mark_o | output | 1 | Pulse: file mark parsed |
| eom_o | output | 1 | Pulse: end of medium |
| len_err_o | output | 1 | Pulse: oversize header |
| frame_err_o | output | 1 | Pulse: trailer mismatch |
| trunc_err_o | output | 1 | Pulse: stream ended inside a record |

## Verification
Two functions can land in the same cycle: the completion of a field, and the end-of-stream strobe. In that case a file mark or a matched trailer must be reported together with end of medium, not as a truncation. The bench provokes this by raising in_eos_i on the final byte of a zero header and on the final trailer byte of a maximum-length record. It also raises in_eos_i alone inside a header, a payload, a filler slot and a trailer. A behavioural reference model steps on every clock and predicts each pulse. The bench flags the coincident pairs file_mark_o with eom_o, and rec_done_o with eom_o, once each.

// File: rtl/tfp_pkg.sv
package tfp_pkg;
  typedef enum logic [2:0] {
    ST_HEADER  = 3'd0,
    ST_DATA    = 3'd1,
    ST_PAD     = 3'd2,
    ST_TRAILER = 3'd3,
    ST_ERROR   = 3'd4
  } tfp_state_e;

  typedef struct packed {
    logic rec_start;
    logic rec_done;
    logic file_mark;
    logic eom;
    logic len_err;
    logic frame_err;
    logic trunc_err;
  } tfp_events_t;
endpackage

// File: rtl/tfp_field_shift.sv
// Assembles a little-endian length field one byte at a time.
module tfp_field_shift #(
  parameter int unsigned BYTES = 4,
  localparam int unsigned W     = 8 * BYTES,
  localparam int unsigned IDX_W = $clog2(BYTES)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         clear_i,
  input  logic [7:0]   byte_i,
  output logic         done_o,
  output logic         empty_o,
  output logic [W-1:0] value_o
);
  logic [W-1:0]     sh_q;
  logic [IDX_W-1:0] idx_q;

  assign value_o = {byte_i, sh_q[W-1:8]};
  assign done_o  = shift_i && (idx_q == IDX_W'(BYTES - 1));
  assign empty_o = (idx_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (clear_i) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (shift_i) begin
      sh_q  <= value_o;
      idx_q <= done_o ? '0 : idx_q + 1'b1;
    end
  end

  // R1: a completed field leaves the assembler empty for the next one
  p_idx_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> empty_o);
endmodule

// File: rtl/tfp_down_counter.sv
// Remaining-payload counter; zero_o marks the last byte.
module tfp_down_counter #(
  parameter int unsigned W = 17
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  assign zero_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (dec_i)   cnt_q <= cnt_q - 1'b1;
  end

  // R2: payload never runs past the header count
  p_no_underflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dec_i && !load_i && zero_o && $past(zero_o) && $past(dec_i)));
endmodule

// File: rtl/tfp_ctrl.sv
module tfp_ctrl
  import tfp_pkg::*;
#(
  parameter int unsigned FIELD_W = 32,
  parameter int unsigned MAX_LEN = 65536,
  localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  input  logic               in_eos_i,
  output logic               in_ready_o,
  output logic               out_valid_o,
  output logic               out_first_o,
  output logic               out_last_o,
  input  logic               out_ready_i,
  // field assembler
  output logic               shift_o,
  output logic               clear_o,
  input  logic               field_done_i,
  input  logic               field_empty_i,
  input  logic [FIELD_W-1:0] field_val_i,
  // payload counter
  output logic               load_o,
  output logic [LEN_W-1:0]   load_val_o,
  output logic               dec_o,
  input  logic               cnt_zero_i,
  // results
  output logic [LEN_W-1:0]   rec_len_o,
  output tfp_events_t        ev_o
);
  tfp_state_e  state_q, st_mid, state_d;
  tfp_events_t ev_d, ev_q;
  logic [LEN_W-1:0] len_q;
  logic first_q, accept, clean_boundary;

  assign in_ready_o  = (state_q == ST_DATA) ? out_ready_i : 1'b1;
  assign accept      = in_valid_i && in_ready_o;
  assign out_valid_o = (state_q == ST_DATA) && in_valid_i;
  assign out_first_o = out_valid_o && first_q;
  assign out_last_o  = out_valid_o && cnt_zero_i;

  assign shift_o    = accept && ((state_q == ST_HEADER) || (state_q == ST_TRAILER));
  assign clear_o    = in_eos_i;
  assign load_val_o = field_val_i[LEN_W-1:0] - LEN_W'(1);
  assign dec_o      = accept && (state_q == ST_DATA);
  // after this cycle's byte, no partial field is pending
  assign clean_boundary = shift_o ? field_done_i : field_empty_i;

  always_comb begin
    st_mid = state_q;
    ev_d   = '0;
    load_o = 1'b0;
    unique case (state_q)
      ST_HEADER: if (field_done_i) begin
        if (field_val_i == '0) begin
          ev_d.file_mark = 1'b1;
        end else if (field_val_i > FIELD_W'(MAX_LEN)) begin
          ev_d.len_err = 1'b1;
          st_mid       = ST_ERROR;
        end else begin
          ev_d.rec_start = 1'b1;
          load_o         = 1'b1;
          st_mid         = ST_DATA;
        end
      end
      ST_DATA: if (accept && cnt_zero_i) begin
        st_mid = len_q[0] ? ST_PAD : ST_TRAILER;
      end
      ST_PAD: if (accept) st_mid = ST_TRAILER;
      ST_TRAILER: if (field_done_i) begin
        if (field_val_i == FIELD_W'(len_q)) ev_d.rec_done  = 1'b1;
        else                                ev_d.frame_err = 1'b1;
        st_mid = ST_HEADER;
      end
      ST_ERROR: ;
      default: st_mid = ST_HEADER;
    endcase

    // end of stream is applied after the byte of the same cycle
    state_d = st_mid;
    if (in_eos_i) begin
      if ((st_mid == ST_HEADER) && clean_boundary) ev_d.eom       = 1'b1;
      else if (st_mid != ST_ERROR)                 ev_d.trunc_err = 1'b1;
      state_d = ST_HEADER;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HEADER;
      ev_q    <= '0;
      len_q   <= '0;
      first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ev_q    <= ev_d;
      if (load_o) len_q <= field_val_i[LEN_W-1:0];
      if (load_o)     first_q <= 1'b1;
      else if (dec_o) first_q <= 1'b0;
    end
  end

  assign rec_len_o = len_q;
  assign ev_o      = ev_q;

  // R5: one completed field yields at most one field outcome
  p_field_outcome_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ev_q.rec_start, ev_q.rec_done, ev_q.frame_err, ev_q.file_mark, ev_q.len_err}));
  // R2: the last payload byte leaves the payload state
  p_last_leaves_data_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && out_last_o && !in_eos_i) |=> (state_q != ST_DATA));
  // R3: filler byte is followed by the trailer
  p_pad_to_trailer_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAD && in_valid_i && !in_eos_i) |=> (state_q == ST_TRAILER));
  // R7: drop state is left only through end of stream
  p_error_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERROR && !in_eos_i) |=> (state_q == ST_ERROR));
  // R9: end of stream always returns to header parsing
  p_eos_to_header_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_eos_i |=> (state_q == ST_HEADER && field_empty_i));
  // R8: end of medium and truncation are exclusive
  p_eom_vs_trunc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ev_q.eom && ev_q.trunc_err));
endmodule

// File: rtl/tape_frame_parser.sv
module tape_frame_parser
  import tfp_pkg::*;
#(
  parameter int unsigned FIELD_BYTES = 4,
  parameter int unsigned MAX_LEN     = 65536,
  localparam int unsigned FIELD_W    = 8 * FIELD_BYTES,
  localparam int unsigned LEN_W      = $clog2(MAX_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  input  logic             in_eos_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  output logic             out_first_o,
  output logic             out_last_o,
  input  logic             out_ready_i,
  output logic [LEN_W-1:0] rec_len_o,
  output logic             rec_start_o,
  output logic             rec_done_o,
  output logic             file_mark_o,
  output logic             eom_o,
  output logic             len_err_o,
  output logic             frame_err_o,
  output logic             trunc_err_o
);
  logic               shift, clear, field_done, field_empty;
  logic [FIELD_W-1:0] field_val;
  logic               load, dec, cnt_zero;
  logic [LEN_W-1:0]   load_val;
  tfp_events_t        ev;

  tfp_field_shift #(.BYTES(FIELD_BYTES)) u_field (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (shift),
    .clear_i (clear),
    .byte_i  (in_data_i),
    .done_o  (field_done),
    .empty_o (field_empty),
    .value_o (field_val)
  );

  tfp_down_counter #(.W(LEN_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .dec_i      (dec),
    .zero_o     (cnt_zero)
  );

  tfp_ctrl #(.FIELD_W(FIELD_W), .MAX_LEN(MAX_LEN)) u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .in_valid_i    (in_valid_i),
    .in_eos_i      (in_eos_i),
    .in_ready_o    (in_ready_o),
    .out_valid_o   (out_valid_o),
    .out_first_o   (out_first_o),
    .out_last_o    (out_last_o),
    .out_ready_i   (out_ready_i),
    .shift_o       (shift),
    .clear_o       (clear),
    .field_done_i  (field_done),
    .field_empty_i (field_empty),
    .field_val_i   (field_val),
    .load_o        (load),
    .load_val_o    (load_val),
    .dec_o         (dec),
    .cnt_zero_i    (cnt_zero),
    .rec_len_o     (rec_len_o),
    .ev_o          (ev)
  );

  assign out_data_o  = in_data_i;
  assign rec_start_o = ev.rec_start;
  assign rec_done_o  = ev.rec_done;
  assign file_mark_o = ev.file_mark;
  assign eom_o       = ev.eom;
  assign len_err_o   = ev.len_err;
  assign frame_err_o = ev.frame_err;
  assign trunc_err_o = ev.trunc_err;

  // R6: a file mark never coincides with a record start
  p_fm_not_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(file_mark_o && rec_start_o));
endmodule

// File: tb/tape_frame_parser_bench.sv
module tape_frame_parser_bench;
  localparam int MAXL = 65536;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_eos = 1'b0, out_ready = 1'b1;
  logic [7:0]  in_data = '0;
  logic        in_ready, out_valid, out_first, out_last;
  logic [7:0]  out_data;
  logic [16:0] rec_len;
  logic        rec_start, rec_done, file_mark, eom, len_err, frame_err, trunc_err;

  always #2.5 clk = ~clk;

  tape_frame_parser u_tape_frame_parser (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_eos_i(in_eos), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_first_o(out_first),
    .out_last_o(out_last), .out_ready_i(out_ready), .rec_len_o(rec_len),
    .rec_start_o(rec_start), .rec_done_o(rec_done), .file_mark_o(file_mark),
    .eom_o(eom), .len_err_o(len_err), .frame_err_o(frame_err), .trunc_err_o(trunc_err)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input longint act, input longint exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // stimulus: [9]=eos [8]=valid [7:0]=data
  logic [9:0] stim_q[$];
  task automatic push_b(input logic [7:0] d, input bit eos = 0);
    stim_q.push_back({eos, 1'b1, d});
  endtask
  task automatic push_eos();
    stim_q.push_back(10'h200);
  endtask
  task automatic push_field(input longint v, input bit eos_last = 0);
    for (int k = 0; k < 4; k++) push_b(8'((v >> (8 * k)) & 255), eos_last && (k == 3));
  endtask
  task automatic push_rec(input int n, input longint trail, input bit eos_last = 0);
    push_field(n);
    for (int i = 0; i < n; i++) push_b(8'(i * 7 + 3));
    if (n % 2) push_b(8'hEE);
    push_field(trail, eos_last);
  endtask

  // reference model state
  int mst = 0, nb = 0;          // 0 header,1 data,2 pad,3 trailer,4 drop
  longint fld = 0, hdr = 0, rem = 0;
  bit e_rs, e_rd, e_fm, e_eom, e_le, e_fe, e_te;
  longint e_len = 0;
  int lens_q[$];
  int dcnt = 0;
  bit saw_fm_eom = 0, saw_rd_eom = 0;

  initial begin
    for (int c = 0; c < 190000; c++) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic lfsr_bit;
    logic [7:0] lfsr = 8'h5A;
    bit v, e, mready, acc;
    logic [7:0] d;
    int idle;
    {e_rs, e_rd, e_fm, e_eom, e_le, e_fe, e_te} = '0;

    push_rec(5, 5);                 // odd, filler
    push_rec(4, 4);
    push_field(0);                  // file mark
    push_rec(1, 1);
    push_rec(3, 7);                 // mismatch
    push_rec(2, 2);                 // resync
    push_field(0, 1);               // file mark + eos same cycle
    push_eos();                     // empty stream end
    push_b(8'h01); push_b(8'h00); push_eos();               // partial header
    push_field(6); push_b(1); push_b(2); push_b(3); push_eos(); // mid payload
    push_field(3); push_b(1); push_b(2); push_b(3); push_eos(); // at filler
    push_field(2); push_b(9); push_b(8); push_b(2); push_b(0); push_eos(); // in trailer
    push_field(MAXL + 1);           // oversize
    for (int i = 0; i < 10; i++) push_b(8'(i));
    push_eos();
    push_rec(MAXL, MAXL, 1);        // max record, eos on last trailer byte

    repeat (3) @(negedge clk);
    // R11: reset state
    chk(in_ready, 1, "R11 in_ready");
    chk(out_valid, 0, "R11 out_valid");
    chk({rec_start, rec_done, file_mark, eom, len_err, frame_err, trunc_err}, 0, "R11 events");
    chk(rec_len, 0, "R11 rec_len");
    rst_n = 1'b1;

    idle = 0;
    while (idle < 4) begin
      @(negedge clk);
      chk(rec_start, e_rs, "R1 rec_start");
      chk(rec_len, e_len, "R1 rec_len");
      chk(rec_done, e_rd, "R4 rec_done");
      chk(frame_err, e_fe, "R5 frame_err");
      chk(file_mark, e_fm, "R6 file_mark");
      chk(len_err, e_le, "R7 len_err");
      chk(eom, e_eom, "R8 eom");
      chk(trunc_err, e_te, "R9 trunc_err");
      if (file_mark && eom) saw_fm_eom = 1;
      if (rec_done && eom) saw_rd_eom = 1;
      if (e_rd) begin lens_q.push_back(dcnt); dcnt = 0; end
      if (e_rs) dcnt = 0;

      lfsr_bit = lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3];
      lfsr = {lfsr[6:0], lfsr_bit};
      out_ready = (lfsr[1:0] != 2'b00);
      mready = (mst == 1) ? out_ready : 1'b1;
      if (stim_q.size() > 0) begin
        v = stim_q[0][8]; d = stim_q[0][7:0];
        e = stim_q[0][9] && (!v || mready);
      end else begin
        v = 0; d = '0; e = 0; idle++;
      end
      in_valid = v; in_data = d; in_eos = e;
      #1;
      chk(in_ready, mready, "R2 in_ready");
      chk(out_valid, (mst == 1) && v, "R2 out_valid");
      if (mst == 1 && v) begin
        chk(out_data, d, "R2 out_data");
        chk(out_first, rem == hdr, "R2 out_first");
        chk(out_last, rem == 1, "R2 out_last");
      end
      if (out_valid && out_ready) dcnt++;

      acc = v && mready;
      {e_rs, e_rd, e_fm, e_eom, e_le, e_fe, e_te} = '0;
      if (acc) begin
        case (mst)
          0: begin
            fld |= longint'(d) << (8 * nb); nb++;
            if (nb == 4) begin
              nb = 0;
              if (fld == 0) e_fm = 1;
              else if (fld > MAXL) begin e_le = 1; mst = 4; end
              else begin e_rs = 1; e_len = fld; hdr = fld; rem = fld; mst = 1; end
              fld = 0;
            end
          end
          1: begin rem--; if (rem == 0) mst = (hdr % 2) ? 2 : 3; end
          2: mst = 3;
          3: begin
            fld |= longint'(d) << (8 * nb); nb++;
            if (nb == 4) begin
              if (fld == hdr) e_rd = 1; else e_fe = 1;
              mst = 0; nb = 0; fld = 0;
            end
          end
          default: ;
        endcase
      end
      if (e) begin
        if (mst == 0 && nb == 0) e_eom = 1;
        else if (mst != 4) e_te = 1;
        mst = 0; nb = 0; fld = 0;
      end
      if (stim_q.size() > 0 && (!v || mready)) void'(stim_q.pop_front());
    end

    // R3 / R12: delivered byte counts of completed records
    chk(lens_q.size(), 5, "R3 completed record count");
    if (lens_q.size() == 5) begin
      chk(lens_q[0], 5, "R3 odd record delivered bytes");
      chk(lens_q[1], 4, "R2 even record delivered bytes");
      chk(lens_q[2], 1, "R3 one-byte record delivered bytes");
      chk(lens_q[3], 2, "R5 resync record delivered bytes");
      chk(lens_q[4], MAXL, "R12 max record delivered bytes");
    end
    chk(saw_fm_eom, 1, "R10 file mark with eom");
    chk(saw_rd_eom, 1, "R10 record done with eom");

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule